// File: doc/BRIEF.md
# Padded Packet Writer for a Half-Full-Flagged Byte FIFO

This block takes a byte stream framed by start and end markers and writes each packet, one byte per write, into an external asynchronous FIFO that is used eight bits wide. The write strobe is active low and lasts one clock. The FIFO's three status flags are active low and arrive without any timing relation to the local clock. The block passes them through a synchronizer before it acts on them.

Every packet reaches the FIFO with one fixed length, `PKT_LEN` words, and that length is larger than half the FIFO depth. A short packet is extended with zero bytes and a long one is cut. This means the half-full flag goes low exactly when a whole packet is in the FIFO. The host processor reads the FIFO over its own bus and uses that flag as its "packet ready" indication. The block does not begin the next packet until it has seen the half-full flag go low and then seen the empty flag report that the host has drained the FIFO.

Top module: `pkt_pad_writer`

## Requirements
- R1: After reset, `fifo_wr_n` is high and `in_ready` is low. The block accepts no input until the synchronized empty flag reports an empty FIFO.
- R2: A byte accepted as part of a packet produces exactly one write carrying that byte, and bytes are written in arrival order. `fifo_wr_n` is low for exactly one clock per write and is high for at least one clock between two writes.
- R3: A packet shorter than `PKT_LEN` bytes is followed by filler writes of value 0x00, so that the packet occupies exactly `PKT_LEN` FIFO words.
- R4: A packet of exactly `PKT_LEN` bytes is written unchanged, with no filler.
- R5: In a packet longer than `PKT_LEN` bytes, only the first `PKT_LEN` bytes are written. The remaining bytes up to and including the end marker are accepted and dropped.
- R6: Bytes that arrive while the block is waiting for a start marker, and do not carry the start marker, are accepted and produce no write.
- R7: A byte that carries both the start and end markers forms a one-byte packet. It is written first and is followed by `PKT_LEN-1` filler bytes.
- R8: While the synchronized full flag is low, there are no writes and `in_ready` is low. Writing resumes where it stopped once the flag returns high.
- R9: After a packet's final write, `in_ready` stays low until the half-full flag has been seen low and then the empty flag has been seen low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Input byte is present |
| in_ready | output | 1 | Block takes the byte at this clock edge |
| in_data | input | DATA_W | Input byte |
| in_sop | input | 1 | Byte is the first of a packet |
| in_eop | input | 1 | Byte is the last of a packet |
| fifo_wr_n | output | 1 | FIFO write strobe, active low, one clock long |
| fifo_data | output | DATA_W | Word written to the FIFO |
| fifo_full_n | input | 1 | FIFO full flag, active low, asynchronous |
| fifo_half_n | input | 1 | FIFO more-than-half-full flag, active low, asynchronous |
| fifo_empty_n | input | 1 | FIFO empty flag, active low, asynchronous |

## Verification
The bench runs every packet length from one byte to several bytes past `PKT_LEN` on a FIFO that is 16 words deep. It targets three kinds of error:
- An off-by-one at the padding boundary would leave the FIFO one word short of half full, so the host would never see a packet. It could also write one extra word, which would shift every later packet.
- A writer that held the strobe low across back-to-back writes would give the FIFO no edge for the second word.
- A writer that ignored the stored-packet handshake or the full flag would start the next packet on top of one that has not been drained.

The bench also sends stray bytes outside any packet, and it forces the full flag low in the middle of a packet. In both cases it checks that the resulting word sequence has no gaps and no duplicates.

// File: rtl/pw_pkg.sv
package pw_pkg;
    typedef enum logic [2:0] {
        PW_WAIT_EMPTY,
        PW_IDLE,
        PW_BODY,
        PW_SKIP,
        PW_FILL,
        PW_WAIT_HALF
    } pw_state_e;
endpackage

// File: rtl/pw_flag_sync.sv
module pw_flag_sync #(
    parameter int WIDTH  = 3,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);
    typedef struct packed {
        logic [STAGES-1:0][WIDTH-1:0] chain;
    } sync_t;

    sync_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        s_d.chain[0] = async_i;
        for (int i = 1; i < STAGES; i++) begin
            s_d.chain[i] = s_q.chain[i-1];
        end
    end

    // Flags are active low, so reset them to the inactive (high) value.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '{chain: '1};
        else        s_q <= s_d;
    end

    assign sync_o = s_q.chain[STAGES-1];
endmodule

// File: rtl/pw_word_ctr.sv
module pw_word_ctr #(
    parameter int LIMIT = 4097,
    localparam int CW   = $clog2(LIMIT + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic inc,
    output logic at_last
);
    typedef struct packed {
        logic [CW-1:0] cnt;
    } ctr_t;

    ctr_t c_d, c_q;

    always_comb begin
        c_d = c_q;
        if (clr)      c_d.cnt = '0;
        else if (inc) c_d.cnt = c_q.cnt + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) c_q <= '0;
        else        c_q <= c_d;
    end

    assign at_last = (c_q.cnt == CW'(LIMIT - 1));

    // R3
    cnt_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        c_q.cnt <= CW'(LIMIT));
endmodule

// File: rtl/pw_wr_port.sv
module pw_wr_port #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              go,
    input  logic [DATA_W-1:0] byte_i,
    output logic              wr_n,
    output logic [DATA_W-1:0] data_o
);
    typedef struct packed {
        logic              wr_n;
        logic [DATA_W-1:0] data;
    } port_t;

    port_t p_d, p_q;

    always_comb begin
        p_d      = p_q;
        p_d.wr_n = 1'b1;
        if (go) begin
            p_d.wr_n = 1'b0;
            p_d.data = byte_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) p_q <= '{wr_n: 1'b1, data: '0};
        else        p_q <= p_d;
    end

    assign wr_n   = p_q.wr_n;
    assign data_o = p_q.data;

    // R2
    wr_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_n |=> wr_n);
endmodule

// File: rtl/pkt_pad_writer.sv
module pkt_pad_writer
    import pw_pkg::*;
#(
    parameter int FIFO_DEPTH  = 8192,
    parameter int PKT_LEN     = 4097,
    parameter int DATA_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [DATA_W-1:0] in_data,
    input  logic              in_sop,
    input  logic              in_eop,
    output logic              fifo_wr_n,
    output logic [DATA_W-1:0] fifo_data,
    input  logic              fifo_full_n,
    input  logic              fifo_half_n,
    input  logic              fifo_empty_n
);
    localparam int HALF_MARK = FIFO_DEPTH / 2;

    if (PKT_LEN <= HALF_MARK || PKT_LEN > FIFO_DEPTH) begin : g_len_bad
        $error("PKT_LEN must exceed half of FIFO_DEPTH and fit in it");
    end

    logic [2:0] flags_s;
    logic       full_ok, half_low, empty_low;

    pw_flag_sync #(.WIDTH(3), .STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .async_i({fifo_empty_n, fifo_half_n, fifo_full_n}),
        .sync_o (flags_s)
    );

    assign full_ok   = flags_s[0];
    assign half_low  = !flags_s[1];
    assign empty_low = !flags_s[2];

    typedef struct packed {
        pw_state_e state;
    } fsm_t;

    fsm_t f_d, f_q;

    logic              go, ctr_clr, ctr_inc, at_last, rdy;
    logic [DATA_W-1:0] wbyte;
    logic              wr_idle;

    assign wr_idle = fifo_wr_n;

    always_comb begin
        f_d     = f_q;
        go      = 1'b0;
        wbyte   = in_data;
        ctr_clr = 1'b0;
        ctr_inc = 1'b0;
        rdy     = 1'b0;
        unique case (f_q.state)
            PW_WAIT_EMPTY: begin
                if (empty_low) begin
                    f_d.state = PW_IDLE;
                    ctr_clr   = 1'b1;
                end
            end
            PW_IDLE: begin
                rdy = full_ok;
                if (in_valid && rdy && in_sop) begin
                    go        = 1'b1;
                    ctr_inc   = 1'b1;
                    f_d.state = in_eop ? PW_FILL : PW_BODY;
                end
            end
            PW_BODY: begin
                rdy = full_ok && wr_idle;
                if (in_valid && rdy) begin
                    go      = 1'b1;
                    ctr_inc = 1'b1;
                    if (at_last)     f_d.state = in_eop ? PW_WAIT_HALF : PW_SKIP;
                    else if (in_eop) f_d.state = PW_FILL;
                end
            end
            PW_SKIP: begin
                rdy = 1'b1;
                if (in_valid && in_eop) f_d.state = PW_WAIT_HALF;
            end
            PW_FILL: begin
                wbyte = '0;
                if (full_ok && wr_idle) begin
                    go      = 1'b1;
                    ctr_inc = 1'b1;
                    if (at_last) f_d.state = PW_WAIT_HALF;
                end
            end
            PW_WAIT_HALF: begin
                if (half_low) f_d.state = PW_WAIT_EMPTY;
            end
            default: f_d.state = PW_WAIT_EMPTY;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) f_q <= '{state: PW_WAIT_EMPTY};
        else        f_q <= f_d;
    end

    assign in_ready = rdy;

    pw_word_ctr #(.LIMIT(PKT_LEN)) u_ctr (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (ctr_clr),
        .inc    (ctr_inc),
        .at_last(at_last)
    );

    pw_wr_port #(.DATA_W(DATA_W)) u_port (
        .clk   (clk),
        .rst_n (rst_n),
        .go    (go),
        .byte_i(wbyte),
        .wr_n  (fifo_wr_n),
        .data_o(fifo_data)
    );

    // R8
    full_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !full_ok |=> fifo_wr_n);

    // R3
    pad_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(f_q.state == PW_FILL) && !fifo_wr_n) |-> (fifo_data == '0));

    // R6
    stray_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (f_q.state == PW_IDLE && in_valid && !in_sop) |=> fifo_wr_n);

    // R9
    drain_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (f_q.state == PW_WAIT_HALF) |=> (fifo_wr_n && !in_ready));
endmodule

// File: tb/pkt_pad_writer_test.sv
module pkt_pad_writer_test;
    localparam int DEPTH = 16;
    localparam int PLEN  = 9;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       in_valid = 1'b0, in_sop = 1'b0, in_eop = 1'b0;
    logic [7:0] in_data = '0;
    logic       in_ready, fifo_wr_n;
    logic [7:0] fifo_data;
    logic       fifo_full_n, fifo_half_n, fifo_empty_n;

    int  checks = 0, errors = 0;
    int  fcount = 0;
    bit  drain_en = 1'b0, force_full = 1'b0, prev_low = 1'b0, tick = 1'b0;
    byte unsigned got[$];

    always #5 clk = ~clk;

    assign fifo_full_n  = !(force_full || fcount >= DEPTH);
    assign fifo_half_n  = !(fcount > DEPTH / 2);
    assign fifo_empty_n = (fcount != 0);

    pkt_pad_writer #(.FIFO_DEPTH(DEPTH), .PKT_LEN(PLEN), .DATA_W(8), .SYNC_STAGES(2)) uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_data(in_data), .in_sop(in_sop), .in_eop(in_eop),
        .fifo_wr_n(fifo_wr_n), .fifo_data(fifo_data),
        .fifo_full_n(fifo_full_n), .fifo_half_n(fifo_half_n), .fifo_empty_n(fifo_empty_n)
    );

    // Behavioural FIFO stand-in plus host drain, updated away from the active edge.
    always @(negedge clk) begin
        int n;
        n = fcount;
        if (rst_n && !fifo_wr_n) begin
            if (prev_low) begin
                errors++;
                $display("FAIL R2 strobe low two cycles: actual=low expected=high");
            end
            checks++;
            got.push_back(fifo_data);
            n++;
        end
        prev_low = rst_n && !fifo_wr_n;
        tick = !tick;
        if (drain_en && fcount > 0 && tick) n--;
        fcount = n;
    end

    task automatic check(bit ok, string req, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic send_byte(byte unsigned d, bit s, bit e);
        @(negedge clk);
        in_valid = 1'b1; in_data = d; in_sop = s; in_eop = e;
        while (!in_ready) @(negedge clk);
        @(posedge clk);
        #1;
        in_valid = 1'b0; in_sop = 1'b0; in_eop = 1'b0;
    endtask

    function automatic byte unsigned pat(int p, int i);
        return byte'((p * 37 + i * 11 + 1) & 8'hFF);
    endfunction

    task automatic run_pkt(int len, int p, int stall_at);
        int snap;
        got.delete();
        drain_en = 1'b0;
        fork
            for (int i = 0; i < len; i++) send_byte(pat(p, i), i == 0, i == len - 1);
            if (stall_at > 0) begin
                for (int k = 0; k < 400 && got.size() < stall_at; k++) @(negedge clk);
                force_full = 1'b1;
                repeat (4) @(negedge clk);
                snap = got.size();
                repeat (12) @(negedge clk);
                check(got.size() == snap, "R8 writes during full", got.size(), snap);
                check(in_ready == 1'b0, "R8 ready during full", in_ready, 0);
                force_full = 1'b0;
            end
        join
        for (int k = 0; k < 400 && got.size() < PLEN; k++) @(negedge clk);
        repeat (10) @(negedge clk);
        check(got.size() == PLEN,
              len < PLEN ? "R3 padded length" : (len == PLEN ? "R4 exact length" : "R5 truncated length"),
              got.size(), PLEN);
        for (int i = 0; i < PLEN && i < got.size(); i++) begin
            int exp;
            exp = (i < len) ? int'(pat(p, i)) : 0;
            check(int'(got[i]) == exp,
                  len == 1 ? "R7 single-byte word" : (i < len ? "R2 data word" : "R3 filler word"),
                  got[i], exp);
        end
        check(in_ready == 1'b0, "R9 held before drain", in_ready, 0);
        drain_en = 1'b1;
        for (int k = 0; k < 200 && !(fcount == 0 && in_ready); k++) @(negedge clk);
        check(in_ready == 1'b1, "R9 resume after drain", in_ready, 1);
    endtask

    task automatic stray(int n);
        got.delete();
        for (int i = 0; i < n; i++) send_byte(8'hA0 + 8'(i), 1'b0, i == n - 1);
        repeat (6) @(negedge clk);
        check(got.size() == 0, "R6 stray bytes written", got.size(), 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL R9 watchdog: actual=hung expected=finish");
        $display("== %0d vectors applied, %0d miscompares ==", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(fifo_wr_n == 1'b1, "R1 strobe after reset", fifo_wr_n, 1);
        check(in_ready == 1'b0, "R1 ready after reset", in_ready, 0);
        for (int k = 0; k < 20 && !in_ready; k++) @(negedge clk);
        check(in_ready == 1'b1, "R1 ready once empty seen", in_ready, 1);
        stray(3);
        for (int len = 1; len <= PLEN + 4; len++) begin
            run_pkt(len, len, 0);
            if (len % 4 == 0) stray(2);
        end
        run_pkt(6, 50, 3);
        run_pkt(PLEN + 2, 51, 5);
        run_pkt(1, 52, 0);
        $display("== %0d vectors applied, %0d miscompares ==", checks, errors);
        $finish;
    end
endmodule